// File: doc/BRIEF.md
# Read/Write Queue Arbiter with Watermark Write Draining

This block decides, every cycle, which pending memory request a controller should issue next. Reads and writes are held in two separate queues, each presented as a vector of per-entry flags: one saying the entry holds a request, one saying that request could be issued this cycle. Entries are numbered in arrival order, so the arbiter always prefers the oldest request that is ready.

Reads normally win. Writes pile up in their own queue until its occupancy climbs past a high watermark. The arbiter then switches to a drain mode and serves only writes until occupancy has fallen to a low watermark. The gap between the two marks keeps the arbiter from flipping between modes on every request. When the read queue holds nothing at all, writes are served even without drain mode, so idle read cycles are not wasted.

The outputs are combinational from the current flags and the registered mode. They give a grant strobe, which queue is selected, the granted entry index, and the mode itself.

Top module: `rw_drain_arb`

## Requirements
- R1: While reset is asserted and on the first cycle after it, drain_mode is 0. With no valid entries in either queue, grant_vld is 0.
- R2: When the read queue is selected, the grant goes to the lowest-numbered read entry with both its valid and issuable bits set. Entry 0 is the oldest. grant_wr is 0 in this case.
- R3: When drain_mode is 0 and wr_count is strictly greater than HI_MARK at a rising clock edge, drain_mode is 1 after that edge. A wr_count equal to HI_MARK leaves drain_mode at 0.
- R4: When drain_mode is 1 and wr_count is less than or equal to LO_MARK at a rising edge, drain_mode is 0 after that edge. While wr_count stays above LO_MARK, drain_mode remains 1 even when reads are pending.
- R5: While drain_mode is 1, grant_wr is 1 and the read flags have no effect. The grant goes to the lowest-numbered write entry with both its valid and issuable bits set.
- R6: While drain_mode is 0 and no read entry is valid, the write queue is selected (grant_wr is 1) and its oldest issuable valid entry is granted. drain_mode stays 0.
- R7: If no entry of the selected queue is both valid and issuable, grant_vld is 0 and grant_idx is 0. The other queue is not used as a fallback, and drain_mode changes only by R3 and R4.
- R8: An entry whose issuable bit is set while its valid bit is clear is never granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid | input | RD_DEPTH | Read entry holds a request, bit 0 oldest |
| rd_issuable | input | RD_DEPTH | Read entry can issue this cycle |
| wr_valid | input | WR_DEPTH | Write entry holds a request, bit 0 oldest |
| wr_issuable | input | WR_DEPTH | Write entry can issue this cycle |
| wr_count | input | $clog2(WR_DEPTH+1) | Write queue occupancy |
| grant_vld | output | 1 | A request is granted this cycle |
| grant_wr | output | 1 | Selected queue: 1 write, 0 read |
| grant_idx | output | max index width | Granted entry index, 0 when no grant |
| drain_mode | output | 1 | Write drain mode active |

## Verification
Directed patterns come first. Read vectors have scattered issuable bits, so picking the oldest can be told apart from picking the newest or any valid entry. Vectors with issuable bits on invalid entries separate a proper AND of the two flags from an issuable-only selection. Occupancy is stepped across 40/41 and 21/20 to pin down the strict and non-strict comparisons and the hysteresis. Empty-read and nothing-issuable cases separate opportunistic draining from wrongly falling back to the other queue. A long run of random flag and occupancy patterns is then compared cycle by cycle against a behavioural model.

// File: rtl/rw_drain_arb.sv
module rw_drain_arb #(
  parameter int RD_DEPTH = 16,
  parameter int WR_DEPTH = 64,
  parameter int HI_MARK  = 40,
  parameter int LO_MARK  = 20,
  localparam int CW  = $clog2(WR_DEPTH + 1),
  localparam int RIW = $clog2(RD_DEPTH),
  localparam int WIW = $clog2(WR_DEPTH),
  localparam int IW  = (RIW > WIW) ? RIW : WIW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [RD_DEPTH-1:0] rd_valid,
  input  logic [RD_DEPTH-1:0] rd_issuable,
  input  logic [WR_DEPTH-1:0] wr_valid,
  input  logic [WR_DEPTH-1:0] wr_issuable,
  input  logic [CW-1:0]       wr_count,
  output logic                grant_vld,
  output logic                grant_wr,
  output logic [IW-1:0]       grant_idx,
  output logic                drain_mode
);
  localparam logic [CW-1:0] HI_C = CW'(HI_MARK);
  localparam logic [CW-1:0] LO_C = CW'(LO_MARK);

  logic [RD_DEPTH-1:0] rd_cand;
  logic [WR_DEPTH-1:0] wr_cand;
  logic                rd_hit, wr_hit;
  logic [IW-1:0]       rd_pick, wr_pick;

  assign rd_cand = rd_valid & rd_issuable;
  assign wr_cand = wr_valid & wr_issuable;

  always_comb begin
    rd_hit  = 1'b0;
    rd_pick = '0;
    for (int i = RD_DEPTH - 1; i >= 0; i--)
      if (rd_cand[i]) begin
        rd_hit  = 1'b1;
        rd_pick = IW'(i);
      end
  end

  always_comb begin
    wr_hit  = 1'b0;
    wr_pick = '0;
    for (int i = WR_DEPTH - 1; i >= 0; i--)
      if (wr_cand[i]) begin
        wr_hit  = 1'b1;
        wr_pick = IW'(i);
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      drain_mode <= 1'b0;
    else if (!drain_mode && wr_count > HI_C)
      drain_mode <= 1'b1;
    else if (drain_mode && wr_count <= LO_C)
      drain_mode <= 1'b0;
  end

  assign grant_wr  = drain_mode || (rd_valid == '0);
  assign grant_vld = grant_wr ? wr_hit : rd_hit;
  assign grant_idx = grant_wr ? wr_pick : rd_pick;
endmodule

// File: rtl/rw_drain_arb_chk.sv
module rw_drain_arb_chk #(
  parameter int RD_DEPTH = 16,
  parameter int WR_DEPTH = 64,
  parameter int HI_MARK  = 40,
  parameter int LO_MARK  = 20,
  localparam int CW  = $clog2(WR_DEPTH + 1),
  localparam int RIW = $clog2(RD_DEPTH),
  localparam int WIW = $clog2(WR_DEPTH),
  localparam int IW  = (RIW > WIW) ? RIW : WIW
) (
  input logic                clk,
  input logic                rst_n,
  input logic [RD_DEPTH-1:0] rd_valid,
  input logic [RD_DEPTH-1:0] rd_issuable,
  input logic [WR_DEPTH-1:0] wr_valid,
  input logic [WR_DEPTH-1:0] wr_issuable,
  input logic [CW-1:0]       wr_count,
  input logic                grant_vld,
  input logic                grant_wr,
  input logic [IW-1:0]       grant_idx,
  input logic                drain_mode
);
  localparam logic [CW-1:0] HI_C = CW'(HI_MARK);
  localparam logic [CW-1:0] LO_C = CW'(LO_MARK);

  logic rd_ok, wr_ok;
  always_comb begin
    rd_ok = 1'b0;
    wr_ok = 1'b0;
    for (int i = 0; i < RD_DEPTH; i++)
      if (grant_idx == IW'(i)) rd_ok = rd_valid[i] & rd_issuable[i];
    for (int i = 0; i < WR_DEPTH; i++)
      if (grant_idx == IW'(i)) wr_ok = wr_valid[i] & wr_issuable[i];
  end

  // R2
  rd_grant_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld && !grant_wr) |-> rd_ok);
  // R8
  wr_grant_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld && grant_wr) |-> wr_ok);
  // R3
  drain_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!drain_mode && wr_count > HI_C) |=> drain_mode);
  // R3
  drain_hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!drain_mode && wr_count <= HI_C) |=> !drain_mode);
  // R4
  drain_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_mode && wr_count <= LO_C) |=> !drain_mode);
  // R4
  drain_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_mode && wr_count > LO_C) |=> drain_mode);
  // R5
  drain_selects_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drain_mode |-> grant_wr);
  // R6
  idle_rd_selects_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid == '0) |-> grant_wr);
  // R7
  no_grant_idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_vld |-> (grant_idx == '0));
endmodule

bind rw_drain_arb rw_drain_arb_chk #(
  .RD_DEPTH(RD_DEPTH), .WR_DEPTH(WR_DEPTH), .HI_MARK(HI_MARK), .LO_MARK(LO_MARK)
) u_chk (.*);

// File: tb/tb_rw_drain_arb.sv
`timescale 1ns/1ps
module tb_rw_drain_arb;
  localparam int RD = 16;
  localparam int WD = 64;
  localparam int HI = 40;
  localparam int LO = 20;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [RD-1:0] rv = '0, ri = '0;
  logic [WD-1:0] wv = '0, wi = '0;
  logic [6:0]    cnt = '0;
  logic          g_vld, g_wr, drain;
  logic [5:0]    g_idx;

  int checks = 0, fails = 0, cycles = 0;
  bit m_drain = 0;

  always #2.5 clk = ~clk;

  rw_drain_arb #(.RD_DEPTH(RD), .WR_DEPTH(WD), .HI_MARK(HI), .LO_MARK(LO)) dut (
    .clk(clk), .rst_n(rst_n), .rd_valid(rv), .rd_issuable(ri),
    .wr_valid(wv), .wr_issuable(wi), .wr_count(cnt),
    .grant_vld(g_vld), .grant_wr(g_wr), .grant_idx(g_idx), .drain_mode(drain));

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) m_drain <= 0;
    else if (!m_drain && int'(cnt) > HI) m_drain <= 1;
    else if (m_drain && int'(cnt) <= LO) m_drain <= 0;
  end

  function automatic int oldest_rd();
    for (int i = 0; i < RD; i++) if (rv[i] && ri[i]) return i;
    return -1;
  endfunction
  function automatic int oldest_wr();
    for (int i = 0; i < WD; i++) if (wv[i] && wi[i]) return i;
    return -1;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cycles);
    end
  endtask

  task automatic compare(string req);
    bit sel_wr;
    int pick;
    sel_wr = m_drain || (rv == '0);
    pick = sel_wr ? oldest_wr() : oldest_rd();
    chk(req, "drain_mode", int'(drain), int'(m_drain));
    chk(req, "grant_wr", int'(g_wr), int'(sel_wr));
    chk(req, "grant_vld", int'(g_vld), int'(pick >= 0));
    chk(req, "grant_idx", int'(g_idx), pick >= 0 ? pick : 0);
  endtask

  task automatic step(string req, logic [RD-1:0] a, logic [RD-1:0] b,
                      logic [WD-1:0] c, logic [WD-1:0] d, int n);
    @(negedge clk);
    rv = a; ri = b; wv = c; wi = d; cnt = 7'(n);
    #1 compare(req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 chk("R1", "drain_mode in reset", int'(drain), 0);
    chk("R1", "grant_vld in reset", int'(g_vld), 0);
    @(negedge clk) rst_n = 1;
    #1 chk("R1", "drain_mode after reset", int'(drain), 0);
    compare("R1");

    step("R2", 16'hFFF0, 16'h0F30, '0, '0, 5);
    step("R2", 16'h8001, 16'h8000, 64'hF, 64'hF, 5);
    step("R2", 16'h00FF, 16'h00AA, 64'h1, 64'h1, 10);
    step("R8", 16'h000C, 16'h0003, 64'h3, 64'h3, 10);
    step("R7", 16'h00F0, 16'h000F, 64'hFF, 64'hFF, 10);

    step("R3", 16'h0001, 16'h0001, 64'h30, 64'h20, HI);
    step("R3", 16'h0001, 16'h0001, 64'h30, 64'h20, HI);
    step("R3", 16'h0001, 16'h0001, 64'h30, 64'h20, HI + 1);
    step("R5", 16'h0001, 16'h0001, 64'h30, 64'h20, LO + 1);
    step("R4", 16'hFFFF, 16'hFFFF, 64'h30, 64'h30, LO + 1);
    step("R5", 16'hFFFF, 16'hFFFF, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, LO + 1);
    step("R7", 16'hFFFF, 16'hFFFF, 64'hF0, 64'h0F, LO + 1);
    step("R8", 16'hFFFF, 16'hFFFF, 64'h0, 64'hFF, LO + 1);
    step("R4", 16'h0004, 16'h0004, 64'h2, 64'h2, LO);
    step("R4", 16'h0004, 16'h0004, 64'h2, 64'h2, LO);

    step("R6", '0, 16'hFFFF, 64'h0F00, 64'h0C00, 10);
    step("R6", '0, '0, 64'h0F00, 64'h0C00, 10);
    step("R7", '0, '0, 64'h0F00, 64'h00F0, 10);
    step("R7", 16'h0002, '0, 64'h1, 64'h1, 10);
    step("R7", '0, '0, '0, '0, 0);

    for (int k = 0; k < 3000; k++) begin
      logic [RD-1:0] a, b;
      logic [WD-1:0] c, d;
      int n;
      string tag;
      a = 16'($urandom) & 16'($urandom);
      if ($urandom_range(0, 4) == 0) a = '0;
      b = 16'($urandom);
      c = {$urandom, $urandom};
      d = {$urandom, $urandom} & {$urandom, $urandom};
      n = (k / 40) % 2 == 0 ? $urandom_range(0, 64) : $urandom_range(15, 45);
      tag = m_drain ? "R5" : (a == '0 ? "R6" : "R2");
      step(tag, a, b, c, d, n);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule